// File: doc/BRIEF.md
# Timing-Wheel Event Scheduler

This block is the scheduling stage of a hardware event-driven logic simulator. It keeps pending events in a circular wheel of time slots. At the start of every simulation step it hands the events due now to an event processor, one per four-phase handshake, and closes the list with an end marker. It then takes in the events an element evaluator produces. Each event carries a payload and an 8-bit delay. A nonzero delay puts the event in the slot that lies that many steps ahead. A zero delay sends it to a small bypass queue, and the same time step is run again so that these events are handed over before time moves on.

When the evaluator signals that it has no more elements, the block releases the slot it has just served. It moves the wheel pointer forward over empty slots and adds the number of slots passed over to the time it will load next. It raises a step-complete flag toward the host and holds it until the host answers with a continue pulse. At that point the new current time is loaded. A comparator raises stop once the current time reaches the final time the host supplies. A stopped scheduler starts no further handshakes.

Top module: `event_sched`

## Requirements
- R1: After reset, next_event_o, no_event_o, accept_o, cycle_complete_o, err_o and cur_time_o are all zero, and the wheel and the bypass queue are empty.
- R2: For each event handed to the processor, next_event_o rises only after ready_i has been seen high. ev_o stays stable while next_event_o is high, and next_event_o falls only after ready_i has been seen low.
- R3: Once every due event has been handed over, no_event_o rises after ready_i is seen high and falls after ready_i is seen low. Only after that does the block start taking in new events. next_event_o and no_event_o are never high together.
- R4: accept_o rises only in answer to new_event_i or no_element_i, and it falls only after that input has returned low.
- R5: An event with a nonzero delta d goes into slot (pointer + d) mod 256, so d = 255 wraps around. It is handed over at time current + d, and events in one slot leave in the order they arrived.
- R6: An event with delta zero bypasses the wheel. The step that follows keeps the same current time and hands over the bypass events after the wheel events of that step, before no_event_o.
- R7: After no_element_i, provided the bypass queue is empty, the pointer skips empty slots. The next current time is the old time plus the number of slots advanced.
- R8: If the wheel holds no event, the advance stops after a full revolution, and the time grows by 256.
- R9: cycle_complete_o is held high until continue_i is sampled high. cur_time_o does not change while cycle_complete_o is high, and the new time is visible in the cycle after the continue.
- R10: An event aimed at a slot that already holds SLOT_DEPTH events is dropped, and err_o is set. err_o stays set until reset.
- R11: A zero-delta event that arrives while the bypass queue holds BYP_DEPTH events is dropped, and err_o is set.
- R12: stop_o is high whenever cur_time_o >= final_time_i. While it is high, no next_event_o or no_event_o handshake begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Processor ready for the next item |
| next_event_o | output | 1 | Valid event on ev_o |
| no_event_o | output | 1 | No more events this step |
| ev_o | output | EV_W | Event payload to the processor |
| new_event_i | input | 1 | Evaluator presents a new event |
| no_element_i | input | 1 | Evaluator has no more elements |
| new_ev_i | input | EV_W | Payload of the new event |
| new_delta_i | input | DELTA_W | Delay of the new event in slots |
| accept_o | output | 1 | Evaluator item taken |
| cycle_complete_o | output | 1 | Step finished, host may read time |
| continue_i | input | 1 | Host releases the next step |
| final_time_i | input | TIME_W | Final simulation time |
| cur_time_o | output | TIME_W | Current simulation time |
| stop_o | output | 1 | Final time reached |
| err_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with a slot depth of 2 and a bypass depth of 2, and keeps the 8-bit delay, which gives a 256-slot wheel. With these depths a third event into one slot, or a third zero-delay event in one step, reaches the drop path. The full-width delay makes the 255-step wrap, a 254-slot skip and the empty-wheel revolution reachable within a short run. The final time is set to match the time reached after the revolution, so stop engages at a known step.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    ST_DISP, ST_DACK, ST_NACK, ST_COLL, ST_NEWACK, ST_ENDACK, ST_SCAN, ST_DONE
  } sched_state_e;
endpackage

// File: rtl/sched_slot_store.sv
module sched_slot_store #(
  parameter int EV_W    = 16,
  parameter int DELTA_W = 8,
  parameter int DEPTH   = 2,
  localparam int SLOTS  = 1 << DELTA_W,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int AW     = $clog2(SLOTS * DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DELTA_W-1:0] wr_slot_i,
  input  logic [EV_W-1:0]    wr_data_i,
  output logic               wr_full_o,
  input  logic [DELTA_W-1:0] rd_slot_i,
  input  logic [CW-1:0]      rd_idx_i,
  output logic [EV_W-1:0]    rd_data_o,
  output logic [CW-1:0]      rd_cnt_o,
  input  logic               clr_en_i
);
  logic [CW-1:0]   cnt_q [SLOTS];
  logic [EV_W-1:0] mem_q [SLOTS*DEPTH];
  logic [AW-1:0]   wr_addr, rd_addr;
  logic            wr_ok;

  assign wr_full_o = (cnt_q[wr_slot_i] == CW'(DEPTH));
  assign wr_ok     = wr_en_i && !wr_full_o;
  assign wr_addr   = AW'(wr_slot_i) * AW'(DEPTH) + AW'(cnt_q[wr_slot_i]);
  assign rd_addr   = AW'(rd_slot_i) * AW'(DEPTH) + AW'(rd_idx_i);
  assign rd_data_o = mem_q[rd_addr];
  assign rd_cnt_o  = cnt_q[rd_slot_i];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              cnt_q[s] <= '0;
      else if (clr_en_i && rd_slot_i == DELTA_W'(s))            cnt_q[s] <= '0;
      else if (wr_ok && wr_slot_i == DELTA_W'(s))               cnt_q[s] <= cnt_q[s] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_addr] <= wr_data_i;
  end
endmodule

// File: rtl/sched_bypass_fifo.sv
module sched_bypass_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         drop_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == NW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign drop_o  = push_i && full;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + NW'(push_ok) - NW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/sched_time.sv
module sched_time #(
  parameter int TIME_W = 16,
  parameter int SKW    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SKW-1:0]    skip_i,
  input  logic [TIME_W-1:0] final_i,
  output logic [TIME_W-1:0] time_o,
  output logic              stop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_o <= '0;
    else if (load_i) time_o <= time_o + TIME_W'(skip_i);
  end
  assign stop_o = (time_o >= final_i);
endmodule

// File: rtl/event_sched.sv
module event_sched
  import sched_pkg::*;
#(
  parameter int EV_W       = 16,
  parameter int DELTA_W    = 8,
  parameter int SLOT_DEPTH = 2,
  parameter int BYP_DEPTH  = 2,
  parameter int TIME_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ready_i,
  output logic               next_event_o,
  output logic               no_event_o,
  output logic [EV_W-1:0]    ev_o,
  input  logic               new_event_i,
  input  logic               no_element_i,
  input  logic [EV_W-1:0]    new_ev_i,
  input  logic [DELTA_W-1:0] new_delta_i,
  output logic               accept_o,
  output logic               cycle_complete_o,
  input  logic               continue_i,
  input  logic [TIME_W-1:0]  final_time_i,
  output logic [TIME_W-1:0]  cur_time_o,
  output logic               stop_o,
  output logic               err_o
);
  localparam int SLOTS = 1 << DELTA_W;
  localparam int CW    = $clog2(SLOT_DEPTH + 1);
  localparam int SKW   = DELTA_W + 1;

  sched_state_e       st_q;
  logic [DELTA_W-1:0] wp_q;
  logic [CW-1:0]      idx_q;
  logic [SKW-1:0]     skip_q;
  logic               src_byp_q;

  logic               take_new, wr_en, wr_full, byp_push, byp_pop, byp_empty, byp_drop;
  logic               clr_en, t_load;
  logic [EV_W-1:0]    rd_data, byp_data;
  logic [CW-1:0]      rd_cnt;

  assign take_new = (st_q == ST_COLL) && new_event_i;
  assign wr_en    = take_new && (new_delta_i != '0);
  assign byp_push = take_new && (new_delta_i == '0);
  assign byp_pop  = (st_q == ST_DACK) && !ready_i && src_byp_q;
  assign clr_en   = (st_q == ST_ENDACK) && !no_element_i;
  assign t_load   = (st_q == ST_DONE) && continue_i;

  sched_slot_store #(.EV_W(EV_W), .DELTA_W(DELTA_W), .DEPTH(SLOT_DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en),
    .wr_slot_i(wp_q + new_delta_i),
    .wr_data_i(new_ev_i),
    .wr_full_o(wr_full),
    .rd_slot_i(wp_q),
    .rd_idx_i (idx_q),
    .rd_data_o(rd_data),
    .rd_cnt_o (rd_cnt),
    .clr_en_i (clr_en)
  );

  sched_bypass_fifo #(.W(EV_W), .DEPTH(BYP_DEPTH)) u_byp (
    .clk_i, .rst_ni,
    .push_i (byp_push),
    .data_i (new_ev_i),
    .pop_i  (byp_pop),
    .data_o (byp_data),
    .empty_o(byp_empty),
    .drop_o (byp_drop)
  );

  sched_time #(.TIME_W(TIME_W), .SKW(SKW)) u_time (
    .clk_i, .rst_ni,
    .load_i (t_load),
    .skip_i (skip_q),
    .final_i(final_time_i),
    .time_o (cur_time_o),
    .stop_o (stop_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_DISP; wp_q <= '0; idx_q <= '0; skip_q <= '0; src_byp_q <= 1'b0;
      ev_o <= '0; next_event_o <= 1'b0; no_event_o <= 1'b0; accept_o <= 1'b0;
      cycle_complete_o <= 1'b0; err_o <= 1'b0;
    end else begin
      if ((wr_en && wr_full) || byp_drop) err_o <= 1'b1;
      unique case (st_q)
        ST_DISP: if (!stop_o && ready_i) begin
          // wheel events first, then zero-delta bypass, then end marker
          if (idx_q < rd_cnt) begin
            ev_o <= rd_data; src_byp_q <= 1'b0; next_event_o <= 1'b1; st_q <= ST_DACK;
          end else if (!byp_empty) begin
            ev_o <= byp_data; src_byp_q <= 1'b1; next_event_o <= 1'b1; st_q <= ST_DACK;
          end else begin
            no_event_o <= 1'b1; st_q <= ST_NACK;
          end
        end
        ST_DACK: if (!ready_i) begin
          next_event_o <= 1'b0;
          if (!src_byp_q) idx_q <= idx_q + 1'b1;
          st_q <= ST_DISP;
        end
        ST_NACK: if (!ready_i) begin
          no_event_o <= 1'b0; st_q <= ST_COLL;
        end
        ST_COLL: if (new_event_i) begin
          accept_o <= 1'b1; st_q <= ST_NEWACK;
        end else if (no_element_i) begin
          accept_o <= 1'b1; st_q <= ST_ENDACK;
        end
        ST_NEWACK: if (!new_event_i) begin
          accept_o <= 1'b0; st_q <= ST_COLL;
        end
        ST_ENDACK: if (!no_element_i) begin
          accept_o <= 1'b0; idx_q <= '0;
          if (!byp_empty) begin
            // delta step: same time, pointer stays
            skip_q <= '0; cycle_complete_o <= 1'b1; st_q <= ST_DONE;
          end else begin
            wp_q <= wp_q + 1'b1; skip_q <= SKW'(1); st_q <= ST_SCAN;
          end
        end
        ST_SCAN: if (rd_cnt != '0 || skip_q == SKW'(SLOTS)) begin
          cycle_complete_o <= 1'b1; st_q <= ST_DONE;
        end else begin
          wp_q <= wp_q + 1'b1; skip_q <= skip_q + 1'b1;
        end
        ST_DONE: if (continue_i) begin
          cycle_complete_o <= 1'b0; st_q <= ST_DISP;
        end
        default: st_q <= ST_DISP;
      endcase
    end
  end
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int EV_W   = 16,
  parameter int TIME_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              next_event_o,
  input logic              no_event_o,
  input logic [EV_W-1:0]   ev_o,
  input logic              new_event_i,
  input logic              no_element_i,
  input logic              accept_o,
  input logic              cycle_complete_o,
  input logic              continue_i,
  input logic [TIME_W-1:0] cur_time_o,
  input logic              stop_o,
  input logic              err_o
);
  assert_next_after_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(next_event_o) |-> $past(ready_i));
  assert_bus_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_event_o && $past(next_event_o)) |-> $stable(ev_o));
  assert_next_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(next_event_o) |-> !$past(ready_i));
  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({next_event_o, no_event_o}));
  assert_noev_after_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_event_o) |-> $past(ready_i));
  assert_noev_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(no_event_o) |-> !$past(ready_i));
  assert_accept_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> $past(new_event_i || no_element_i));
  assert_accept_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(accept_o) |-> !$past(new_event_i) && !$past(no_element_i));
  assert_time_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_complete_o && $past(cycle_complete_o)) |-> $stable(cur_time_o));
  assert_cc_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cycle_complete_o) |-> $past(continue_i));
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_o) |-> err_o);
  assert_stopped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_o) |-> !$rose(next_event_o) && !$rose(no_event_o));
endmodule

bind event_sched sched_chk #(.EV_W(EV_W), .TIME_W(TIME_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .next_event_o(next_event_o),
  .no_event_o(no_event_o), .ev_o(ev_o), .new_event_i(new_event_i),
  .no_element_i(no_element_i), .accept_o(accept_o), .cycle_complete_o(cycle_complete_o),
  .continue_i(continue_i), .cur_time_o(cur_time_o), .stop_o(stop_o), .err_o(err_o)
);

// File: tb/event_sched_tb.sv
`timescale 1ns/1ps
module event_sched_tb;
  localparam int EV_W = 16, DELTA_W = 8, TIME_W = 16;
  localparam logic [TIME_W-1:0] FINAL = 16'd523;

  typedef struct packed {
    logic [1:0]  n_new;
    logic [15:0] e0, e1, e2;
    logic [7:0]  l0, l1, l2;
    logic [2:0]  n_disp;
    logic [15:0] d0, d1;
    logic [15:0] t_pre, t_post;
    logic        err;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd3, 16'h0101, 16'h0102, 16'h0103, 8'd3,   8'd3, 8'd5, 3'd0, 16'h0000, 16'h0000, 16'd0,   16'd3,   1'b0},
    '{2'd2, 16'h0201, 16'h0202, 16'h0000, 8'd0,   8'd2, 8'd0, 3'd2, 16'h0101, 16'h0102, 16'd3,   16'd3,   1'b0},
    '{2'd0, 16'h0000, 16'h0000, 16'h0000, 8'd0,   8'd0, 8'd0, 3'd1, 16'h0201, 16'h0000, 16'd3,   16'd5,   1'b0},
    '{2'd2, 16'h0301, 16'h0302, 16'h0000, 8'd255, 8'd1, 8'd0, 3'd2, 16'h0103, 16'h0202, 16'd5,   16'd6,   1'b0},
    '{2'd0, 16'h0000, 16'h0000, 16'h0000, 8'd0,   8'd0, 8'd0, 3'd1, 16'h0302, 16'h0000, 16'd6,   16'd260, 1'b0},
    '{2'd3, 16'h0401, 16'h0402, 16'h0403, 8'd7,   8'd7, 8'd7, 3'd1, 16'h0301, 16'h0000, 16'd260, 16'd267, 1'b1},
    '{2'd0, 16'h0000, 16'h0000, 16'h0000, 8'd0,   8'd0, 8'd0, 3'd2, 16'h0401, 16'h0402, 16'd267, 16'd523, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ready_i = 1'b0, new_event_i = 1'b0, no_element_i = 1'b0, continue_i = 1'b0;
  logic [EV_W-1:0] new_ev_i = '0;
  logic [DELTA_W-1:0] new_delta_i = '0;
  logic [TIME_W-1:0] final_time_i = FINAL;
  logic next_event_o, no_event_o, accept_o, cycle_complete_o, stop_o, err_o;
  logic [EV_W-1:0] ev_o;
  logic [TIME_W-1:0] cur_time_o;

  int n_chk = 0, n_fail = 0, cycles = 0, n_got = 0;
  logic [15:0] got [4];
  logic [15:0] t_pre, t_post;
  logic err_seen;

  always #10 clk_i = ~clk_i;

  event_sched #(.EV_W(EV_W), .DELTA_W(DELTA_W), .SLOT_DEPTH(2), .BYP_DEPTH(2),
                .TIME_W(TIME_W)) u_dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic dispatch_phase();
    n_got = 0;
    forever begin
      @(negedge clk_i) ready_i = 1'b1;
      while (!(next_event_o || no_event_o)) @(negedge clk_i);
      if (next_event_o) begin
        if (n_got < 4) got[n_got] = ev_o;
        n_got++;
        ready_i = 1'b0;
        while (next_event_o) @(negedge clk_i);
      end else begin
        ready_i = 1'b0;
        while (no_event_o) @(negedge clk_i);
        break;
      end
    end
  endtask

  task automatic send_ev(input logic [15:0] e, input logic [7:0] d);
    @(negedge clk_i);
    new_ev_i = e; new_delta_i = d; new_event_i = 1'b1;
    while (!accept_o) @(negedge clk_i);
    new_event_i = 1'b0;
    while (accept_o) @(negedge clk_i);
  endtask

  task automatic send_end();
    @(negedge clk_i) no_element_i = 1'b1;
    while (!accept_o) @(negedge clk_i);
    no_element_i = 1'b0;
    while (accept_o) @(negedge clk_i);
  endtask

  task automatic finish_step();
    while (!cycle_complete_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    t_pre = cur_time_o; err_seen = err_o;
    check(cycle_complete_o == 1'b1, "R9 step flag held", cycle_complete_o, 1);
    continue_i = 1'b1;
    @(negedge clk_i) continue_i = 1'b0;
    t_post = cur_time_o;
  endtask

  task automatic reset_dut();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(next_event_o == 0 && no_event_o == 0 && accept_o == 0, "R1 handshakes idle",
          {next_event_o, no_event_o, accept_o}, 0);
    check(cycle_complete_o == 0 && err_o == 0, "R1 flags clear", {cycle_complete_o, err_o}, 0);
    check(cur_time_o == 0, "R1 time zero", cur_time_o, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    reset_dut();

    for (int i = 0; i < 7; i++) begin
      dispatch_phase();
      check(n_got == int'(VECS[i].n_disp), "R3 events before end marker", n_got, VECS[i].n_disp);
      if (VECS[i].n_disp > 0)
        check(got[0] == VECS[i].d0, (i == 2) ? "R6 bypass event" : "R5 first event", got[0], VECS[i].d0);
      if (VECS[i].n_disp > 1)
        check(got[1] == VECS[i].d1, "R5 slot order", got[1], VECS[i].d1);
      if (VECS[i].n_new > 0) send_ev(VECS[i].e0, VECS[i].l0);
      if (VECS[i].n_new > 1) send_ev(VECS[i].e1, VECS[i].l1);
      if (VECS[i].n_new > 2) send_ev(VECS[i].e2, VECS[i].l2);
      send_end();
      check(accept_o == 1'b0, "R4 accept released", accept_o, 0);
      finish_step();
      check(t_pre == VECS[i].t_pre, "R9 time held during step flag", t_pre, VECS[i].t_pre);
      check(t_post == VECS[i].t_post, (i == 1) ? "R6 time kept" : (i == 6) ? "R8 full turn" : "R7 skip time",
            t_post, VECS[i].t_post);
      check(err_seen == VECS[i].err, "R10 slot overflow flag", err_seen, VECS[i].err);
      check(stop_o == (VECS[i].t_post >= FINAL), "R12 stop level", stop_o, VECS[i].t_post >= FINAL);
    end

    // stopped: ready held high, no handshake may start
    begin
      int starts = 0;
      @(negedge clk_i) ready_i = 1'b1;
      repeat (20) @(negedge clk_i) if (next_event_o || no_event_o) starts++;
      ready_i = 1'b0;
      check(starts == 0, "R12 no dispatch when stopped", starts, 0);
    end

    final_time_i = 16'd1000;
    reset_dut();

    // three zero-delta events, bypass holds two
    dispatch_phase();
    check(n_got == 0, "R3 empty wheel after reset", n_got, 0);
    send_ev(16'h0601, 8'd0);
    send_ev(16'h0602, 8'd0);
    send_ev(16'h0603, 8'd0);
    send_end();
    finish_step();
    check(err_seen == 1'b1, "R11 bypass overflow flag", err_seen, 1);
    check(t_post == 16'd0, "R6 delta step keeps time", t_post, 0);
    dispatch_phase();
    check(n_got == 2, "R11 third bypass event dropped", n_got, 2);
    check(got[0] == 16'h0601, "R6 bypass order first", got[0], 16'h0601);
    check(got[1] == 16'h0602, "R6 bypass order second", got[1], 16'h0602);
    check(err_o == 1'b1, "R10 flag sticky", err_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule